// File: doc/BRIEF.md
# Keyboard Host Mailbox

This block sits between a host bus and a small 8-bit microcontroller. It works as a two-way mailbox in the manner of a classic keyboard controller. The host drops command or data bytes into a write port. The block records whether each byte was a command or data, taking this from a host address line. The microcontroller loads a byte for the host into an output register. The host collects that byte through its read port.

An output-full flag tells the host that a byte is waiting. In automatic mode the flag is set when the microcontroller writes the output register, and cleared when the host reads it. Firmware can instead take direct ownership of the flag through a one-bit latch. This lets the host run a polled protocol.

The flag drives the keyboard interrupt line only when the interrupt enable input is high. Both configuration enables arrive as plain input pins. All accesses are single-cycle strobes on one clock.

Top module: `kbd_mailbox`

## Requirements
- R1: On each host write strobe, the command tag (status bit 3, microcontroller address 0x7FF4) is loaded from `host_sa2`: 1 marks a command and 0 marks data.
- R2: The host-written byte is readable by the microcontroller at 0x7FF0. It holds its value until the next host write.
- R3: After reset, `obf`, `kirq` and `host_rdata` are 0. A read of 0x7FFD returns 0x00.
- R4: With `cfg_fw_ctrl`=0, a microcontroller write to 0x7FF1 loads `host_rdata` and sets `obf`. The new values are seen the cycle after the strobe.
- R5: With `cfg_fw_ctrl`=0, a host read strobe clears `obf` on the following cycle.
- R6: In automatic mode, a host read and a write to 0x7FF1 in the same cycle leave `obf` set and load the new byte.
- R7: With `cfg_fw_ctrl`=1, `obf` equals the firmware latch at 0x7FFD. Host reads and writes to 0x7FF1 do not change it.
- R8: Writes to the 0x7FFD latch (data bit 0) are stored while automatic mode is selected. They affect `obf` only once `cfg_fw_ctrl` becomes 1.
- R9: A microcontroller read of 0x7FFD returns the present `obf` in bit 0, with bits 7 to 1 as 0. Status reads return `obf` in bit 0 and the tag in bit 3, with all other bits 0.
- R10: `kirq` equals `obf` when `cfg_irq_en`=1, and is 0 when `cfg_irq_en`=0.
- R11: `uc_rdata` is registered: it updates on the clock edge where `uc_rd` is high. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sa2 | input | 1 | Host address bit selecting command (1) or data (0) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data read strobe |
| host_rdata | output | 8 | Byte waiting for the host |
| uc_wr | input | 1 | Microcontroller write strobe |
| uc_rd | input | 1 | Microcontroller read strobe |
| uc_addr | input | 16 | Microcontroller register address |
| uc_wdata | input | 8 | Microcontroller write byte |
| uc_rdata | output | 8 | Registered read data |
| cfg_irq_en | input | 1 | Gates the flag onto the interrupt |
| cfg_fw_ctrl | input | 1 | Selects the firmware latch as the flag source |
| obf | output | 1 | Output-full flag |
| kirq | output | 1 | Keyboard interrupt |

## Verification
The flag-clearing property assumes that `cfg_fw_ctrl` does not rise in the same cycle as a host read. The bench changes configuration pins only on cycles with no strobes active. The latch property makes the same assumption about writes to 0x7FFD. All strobes are driven for one cycle on the falling edge and released on the next falling edge, so each access is seen exactly once.

// File: rtl/kbd_mbx_pkg.sv
package kbd_mbx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned TAG_BIT = 3;
  localparam int unsigned OBF_BIT = 0;
  localparam logic [ADDR_W-1:0] A_IN_BYTE  = 16'h7FF0;
  localparam logic [ADDR_W-1:0] A_OUT_BYTE = 16'h7FF1;
  localparam logic [ADDR_W-1:0] A_STATUS   = 16'h7FF4;
  localparam logic [ADDR_W-1:0] A_FLAG     = 16'h7FFD;
endpackage

// File: rtl/kbd_host_in.sv
module kbd_host_in #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_sa2,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] in_byte,
  output logic          cmd_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte <= '0;
      cmd_tag <= 1'b0;
    end else if (host_wr) begin
      in_byte <= host_wdata;
      cmd_tag <= host_sa2;
    end
  end
endmodule

// File: rtl/kbd_obf_ctrl.sv
module kbd_obf_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic out_wr,
  input  logic host_rd,
  input  logic latch_wr,
  input  logic latch_din,
  input  logic fw_mode,
  output logic obf
);
  logic auto_q;
  logic fw_q;

  // set wins over clear so a byte loaded during a host read is not lost
  always_ff @(posedge clk) begin
    if (rst)          auto_q <= 1'b0;
    else if (out_wr)  auto_q <= 1'b1;
    else if (host_rd) auto_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           fw_q <= 1'b0;
    else if (latch_wr) fw_q <= latch_din;
  end

  assign obf = fw_mode ? fw_q : auto_q;
endmodule

// File: rtl/kbd_uc_readmux.sv
module kbd_uc_readmux
  import kbd_mbx_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          uc_rd,
  input  logic [AW-1:0] uc_addr,
  input  logic [DW-1:0] in_byte,
  input  logic [DW-1:0] out_byte,
  input  logic          cmd_tag,
  input  logic          obf,
  output logic [DW-1:0] uc_rdata
);
  logic [DW-1:0] sel;
  logic [DW-1:0] status_w;
  logic [DW-1:0] flag_w;

  always_comb begin
    status_w          = '0;
    status_w[TAG_BIT] = cmd_tag;
    status_w[OBF_BIT] = obf;
    flag_w            = '0;
    flag_w[0]         = obf;
  end

  always_comb begin
    unique case (uc_addr)
      AW'(A_IN_BYTE):  sel = in_byte;
      AW'(A_OUT_BYTE): sel = out_byte;
      AW'(A_STATUS):   sel = status_w;
      AW'(A_FLAG):     sel = flag_w;
      default:         sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        uc_rdata <= '0;
    else if (uc_rd) uc_rdata <= sel;
  end
endmodule

// File: rtl/kbd_mailbox.sv
module kbd_mailbox
  import kbd_mbx_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_sa2,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          uc_wr,
  input  logic          uc_rd,
  input  logic [AW-1:0] uc_addr,
  input  logic [DW-1:0] uc_wdata,
  output logic [DW-1:0] uc_rdata,
  input  logic          cfg_irq_en,
  input  logic          cfg_fw_ctrl,
  output logic          obf,
  output logic          kirq
);
  logic [DW-1:0] in_byte;
  logic          cmd_tag;
  logic          out_wr;
  logic          latch_wr;

  assign out_wr   = uc_wr && (uc_addr == AW'(A_OUT_BYTE));
  assign latch_wr = uc_wr && (uc_addr == AW'(A_FLAG));

  always_ff @(posedge clk) begin
    if (rst)         host_rdata <= '0;
    else if (out_wr) host_rdata <= uc_wdata;
  end

  kbd_host_in #(.DW(DW)) i_host_in (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sa2(host_sa2),
    .host_wdata(host_wdata), .in_byte(in_byte), .cmd_tag(cmd_tag)
  );

  kbd_obf_ctrl i_obf (
    .clk(clk), .rst(rst), .out_wr(out_wr), .host_rd(host_rd),
    .latch_wr(latch_wr), .latch_din(uc_wdata[0]), .fw_mode(cfg_fw_ctrl),
    .obf(obf)
  );

  kbd_uc_readmux #(.AW(AW), .DW(DW)) i_rmux (
    .clk(clk), .rst(rst), .uc_rd(uc_rd), .uc_addr(uc_addr),
    .in_byte(in_byte), .out_byte(host_rdata), .cmd_tag(cmd_tag),
    .obf(obf), .uc_rdata(uc_rdata)
  );

  assign kirq = cfg_irq_en & obf;
endmodule

// File: rtl/kbd_mailbox_chk.sv
module kbd_mailbox_chk
  import kbd_mbx_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic          host_sa2,
  input logic          host_rd,
  input logic          uc_wr,
  input logic          uc_rd,
  input logic [AW-1:0] uc_addr,
  input logic          uc_wdata0,
  input logic [DW-1:0] uc_rdata,
  input logic          cfg_irq_en,
  input logic          cfg_fw_ctrl,
  input logic          obf,
  input logic          kirq,
  input logic          cmd_tag
);
  logic wr_out, wr_flag;
  assign wr_out  = uc_wr && (uc_addr == AW'(A_OUT_BYTE));
  assign wr_flag = uc_wr && (uc_addr == AW'(A_FLAG));

  // R1
  tag_load_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> cmd_tag == $past(host_sa2));

  // R4
  auto_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_out && !cfg_fw_ctrl) |=> (cfg_fw_ctrl || obf));

  // R5
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !wr_out && !cfg_fw_ctrl) |=> (cfg_fw_ctrl || !obf));

  // R6
  collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && wr_out && !cfg_fw_ctrl) |=> (cfg_fw_ctrl || obf));

  // R7
  fw_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && cfg_fw_ctrl) |=> (!cfg_fw_ctrl || obf == $past(uc_wdata0)));

  // R9
  flag_read_chk: assert property (@(posedge clk) disable iff (rst)
    (uc_rd && uc_addr == AW'(A_FLAG)) |=> uc_rdata[DW-1:1] == '0);

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_irq_en |-> !kirq);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    kirq |-> obf);
endmodule

bind kbd_mailbox kbd_mailbox_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sa2(host_sa2),
  .host_rd(host_rd), .uc_wr(uc_wr), .uc_rd(uc_rd), .uc_addr(uc_addr),
  .uc_wdata0(uc_wdata[0]), .uc_rdata(uc_rdata), .cfg_irq_en(cfg_irq_en),
  .cfg_fw_ctrl(cfg_fw_ctrl), .obf(obf), .kirq(kirq), .cmd_tag(cmd_tag)
);

// File: tb/test_kbd_mailbox.sv
module test_kbd_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 0, host_sa2 = 0, host_rd = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        uc_wr = 0, uc_rd = 0;
  logic [15:0] uc_addr = 0;
  logic [7:0]  uc_wdata = 0;
  logic [7:0]  uc_rdata;
  logic        cfg_irq_en = 0, cfg_fw_ctrl = 0;
  logic        obf, kirq;
  int total = 0, bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  kbd_mailbox i_kbd_mailbox (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sa2(host_sa2),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .uc_wr(uc_wr), .uc_rd(uc_rd), .uc_addr(uc_addr), .uc_wdata(uc_wdata),
    .uc_rdata(uc_rdata), .cfg_irq_en(cfg_irq_en), .cfg_fw_ctrl(cfg_fw_ctrl),
    .obf(obf), .kirq(kirq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic uc_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); uc_wr = 1; uc_addr = a; uc_wdata = d;
    @(negedge clk); uc_wr = 0;
  endtask

  task automatic uc_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); uc_rd = 1; uc_addr = a;
    @(negedge clk); uc_rd = 0; d = uc_rdata;
  endtask

  task automatic h_write(logic sa2, logic [7:0] d);
    @(negedge clk); host_wr = 1; host_sa2 = sa2; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic h_read();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R3 obf", {7'b0, obf}, 8'h00);
    check("R3 kirq", {7'b0, kirq}, 8'h00);
    check("R3 host_rdata", host_rdata, 8'h00);
    uc_read(16'h7FFD, r);
    check("R3 flag read", r, 8'h00);
  endtask

  task automatic t_tag();
    logic [7:0] r;
    h_write(1'b1, 8'hA5);
    uc_read(16'h7FF4, r);
    check("R1 cmd tag", r, 8'h08);
    uc_read(16'h7FF0, r);
    check("R2 byte", r, 8'hA5);
    h_write(1'b0, 8'h3C);
    uc_read(16'h7FF4, r);
    check("R1 data tag", r, 8'h00);
    repeat (3) @(negedge clk);
    uc_read(16'h7FF0, r);
    check("R2 held", r, 8'h3C);
  endtask

  task automatic t_auto();
    logic [7:0] r;
    cfg_irq_en = 1; cfg_fw_ctrl = 0;
    uc_write(16'h7FF1, 8'h5A);
    check("R4 obf set", {7'b0, obf}, 8'h01);
    check("R4 host_rdata", host_rdata, 8'h5A);
    check("R10 kirq on", {7'b0, kirq}, 8'h01);
    uc_read(16'h7FFD, r);
    check("R9 flag read", r, 8'h01);
    uc_read(16'h7FF4, r);
    check("R9 status", r, 8'h01);
    cfg_irq_en = 0;
    @(negedge clk);
    check("R10 kirq gated", {7'b0, kirq}, 8'h00);
    cfg_irq_en = 1;
    h_read();
    check("R5 obf cleared", {7'b0, obf}, 8'h00);
    check("R10 kirq off", {7'b0, kirq}, 8'h00);
  endtask

  task automatic t_collide();
    uc_write(16'h7FF1, 8'h11);
    @(negedge clk);
    host_rd = 1; uc_wr = 1; uc_addr = 16'h7FF1; uc_wdata = 8'h77;
    @(negedge clk);
    host_rd = 0; uc_wr = 0;
    check("R6 obf kept", {7'b0, obf}, 8'h01);
    check("R6 byte", host_rdata, 8'h77);
    h_read();
    check("R5 clear after collide", {7'b0, obf}, 8'h00);
  endtask

  task automatic t_fw();
    logic [7:0] r;
    uc_write(16'h7FFD, 8'h01);
    check("R8 latch no effect", {7'b0, obf}, 8'h00);
    cfg_fw_ctrl = 1;
    @(negedge clk);
    check("R8 latch applied", {7'b0, obf}, 8'h01);
    uc_read(16'h7FFD, r);
    check("R9 fw read", r, 8'h01);
    h_read();
    check("R7 host read ignored", {7'b0, obf}, 8'h01);
    uc_write(16'h7FFD, 8'hFE);
    check("R7 fw clear", {7'b0, obf}, 8'h00);
    uc_write(16'h7FF1, 8'h42);
    check("R7 data write ignored", {7'b0, obf}, 8'h00);
    check("R10 kirq fw", {7'b0, kirq}, 8'h00);
    cfg_fw_ctrl = 0;
    @(negedge clk);
    check("R4 auto restored", {7'b0, obf}, 8'h01);
    h_read();
    check("R5 auto clear", {7'b0, obf}, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    uc_read(16'h1234, r);
    check("R11 unmapped", r, 8'h00);
    @(negedge clk);
    uc_addr = 16'h7FF0;
    @(negedge clk);
    check("R11 no strobe hold", uc_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_tag();
    t_auto();
    t_collide();
    t_fw();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule